// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block drives the analog front end of an integrating (dual-slope) converter. It walks through four phases in a fixed ring: auto-zero, integrate, de-integrate and integrator-zero. It tells the analog section which phase is active through a 2-bit code. A 16-bit timer counts system clock cycles. Auto-zero and integrate share one programmable length. That length is set by an 8-bit preload that becomes the timer's upper byte, so each of these two phases lasts from 256 to 65536 cycles.

De-integration begins on the clock right after integrate ends. It lasts until the comparator input leaves the level it held on the last integrate cycle, or until the timer reaches full scale. When it ends, the block latches three things and marks them with a one-cycle valid pulse: the number of de-integrate cycles, the polarity and an overrange flag. Integrator-zero then holds until the comparator reads high.

A low level on the run enable or on the load strobe restarts the ring at auto-zero. While the load strobe is low, the load value is also taken as the new preload.

Top module: `dslope_sequencer`

## Requirements
- R1: Phase codes are IZ=2'b00, AZ=2'b01, INT=2'b10, DEINT=2'b11. Unless forced, the phase only advances IZ→AZ→INT→DEINT→IZ.
- R2: With preload L, auto-zero lasts exactly 65536−256·L cycles, counted from the first cycle the code reads AZ.
- R3: Integrate lasts the same number of cycles as auto-zero for the same preload.
- R4: DEINT is entered on the clock after the last INT cycle. It ends on the first DEINT cycle in which the comparator differs from its level on the last INT cycle. res_count is then the number of earlier DEINT cycles, so a change seen in the very first DEINT cycle gives 0.
- R5: If the comparator stays unchanged for 65536 DEINT cycles, the result reads res_ovr=1 and res_count=16'hFFFF, and the phase goes to IZ.
- R6: In IZ the phase holds while the comparator is low. It moves to AZ on the clock after the comparator is seen high.
- R7: After reset the phase is IZ, and res_valid, res_count, res_pol and res_ovr are all 0.
- R8: run_en low or ld_n low in a cycle gives AZ in the next cycle with the timer restarted. ld_n low stores load_val as the preload. The reset preload is 0.
- R9: res_pol equals the comparator level on the last INT cycle. res_valid is high for exactly the one cycle after DEINT ends, and the result outputs hold their values until the next capture.
- R10: If the comparator change falls on the same DEINT cycle as full scale, the change wins: res_ovr=0 and res_count=16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_i | input | 1 | Comparator level from the analog front end |
| run_en | input | 1 | Chip enable; low forces auto-zero |
| ld_n | input | 1 | Active-low load strobe; stores load_val and forces auto-zero |
| load_val | input | 8 | Preload for the upper byte of the timer |
| phase | output | 2 | Current phase code |
| res_valid | output | 1 | One-cycle pulse when a new result is latched |
| res_count | output | 16 | De-integration cycle count |
| res_pol | output | 1 | Polarity: comparator level at the end of integration |
| res_ovr | output | 1 | De-integration reached full scale without a comparator change |

## Verification
The comparator-driven end of de-integration and the full-scale end can land on the same clock. The bench provokes this by flipping the comparator exactly 65535 cycles after de-integration begins. It then expects a normal capture with overrange clear and an all-ones count. A second run keeps the comparator still, so that full scale alone ends the phase. A forcing input can also meet a phase boundary. To cover this, run enable is dropped in the middle of integration, and a behavioural model follows every cycle to judge the restarted auto-zero length.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  typedef enum logic [1:0] {
    PH_IZ    = 2'b00,
    PH_AZ    = 2'b01,
    PH_INT   = 2'b10,
    PH_DEINT = 2'b11
  } phase_e;
endpackage

// File: rtl/dsq_timer.sv
module dsq_timer #(
  parameter int TMR_W  = 16,
  parameter int LOAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              ld_i,
  input  logic              inc_i,
  input  logic [LOAD_W-1:0] base_i,
  output logic [TMR_W-1:0]  val_o,
  output logic              full_o
);
  localparam int LOW_W = TMR_W - LOAD_W;

  logic [TMR_W-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (clr_i)      val_d = '0;
    else if (ld_i)  val_d = {base_i, {LOW_W{1'b0}}};
    else if (inc_i) val_d = val_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign val_o  = val_q;
  assign full_o = &val_q;

  // the sequencer never asks the timer to roll over
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !inc_i);
endmodule

// File: rtl/dsq_fsm.sv
module dsq_fsm
  import dsq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   force_i,
  input  logic   cmp_i,
  input  logic   pol_i,
  input  logic   full_i,
  output phase_e phase_o,
  output logic   tmr_ld_o,
  output logic   tmr_clr_o,
  output logic   tmr_inc_o,
  output logic   pol_en_o,
  output logic   cap_o,
  output logic   cap_ovr_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d   = phase_q;
    tmr_ld_o  = 1'b0;
    tmr_clr_o = 1'b0;
    tmr_inc_o = 1'b0;
    pol_en_o  = 1'b0;
    cap_o     = 1'b0;
    cap_ovr_o = 1'b0;
    if (force_i) begin
      phase_d  = PH_AZ;
      tmr_ld_o = 1'b1;
    end else begin
      unique case (phase_q)
        PH_IZ: if (cmp_i) begin
          phase_d  = PH_AZ;
          tmr_ld_o = 1'b1;
        end
        PH_AZ: if (full_i) begin
          phase_d  = PH_INT;
          tmr_ld_o = 1'b1;
        end else tmr_inc_o = 1'b1;
        PH_INT: if (full_i) begin
          phase_d   = PH_DEINT;
          tmr_clr_o = 1'b1;
          pol_en_o  = 1'b1;
        end else tmr_inc_o = 1'b1;
        PH_DEINT: if (cmp_i != pol_i) begin
          phase_d = PH_IZ;
          cap_o   = 1'b1;
        end else if (full_i) begin
          phase_d   = PH_IZ;
          cap_o     = 1'b1;
          cap_ovr_o = 1'b1;
        end else tmr_inc_o = 1'b1;
        default: phase_d = PH_IZ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IZ;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  assert_phase_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(force_i) && phase_q != $past(phase_q)) |->
      (phase_q == phase_e'($past(phase_q) + 2'd1)));

  assert_force_az_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |=> phase_q == PH_AZ);

  assert_iz_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IZ && !cmp_i && !force_i) |=> phase_q == PH_IZ);
endmodule

// File: rtl/dsq_capture.sv
module dsq_capture #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_i,
  input  logic             pol_en_i,
  input  logic             cap_i,
  input  logic             cap_ovr_i,
  input  logic [TMR_W-1:0] tmr_i,
  output logic             pol_o,
  output logic             valid_o,
  output logic [TMR_W-1:0] count_o,
  output logic             res_pol_o,
  output logic             ovr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pol_o <= 1'b0;
    else if (pol_en_i) pol_o <= cmp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o   <= '0;
      res_pol_o <= 1'b0;
      ovr_o     <= 1'b0;
    end else if (cap_i) begin
      count_o   <= tmr_i;
      res_pol_o <= pol_o;
      ovr_o     <= cap_ovr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= cap_i;
  end

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cap_i) |-> ($stable(count_o) && $stable(ovr_o) && $stable(res_pol_o)));

  assert_ovr_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ovr_o) |-> (&count_o));
endmodule

// File: rtl/dslope_sequencer.sv
module dslope_sequencer
  import dsq_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int LOAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_i,
  input  logic              run_en,
  input  logic              ld_n,
  input  logic [LOAD_W-1:0] load_val,
  output logic [1:0]        phase,
  output logic              res_valid,
  output logic [TMR_W-1:0]  res_count,
  output logic              res_pol,
  output logic              res_ovr
);
  logic              rs_meta, rs_n;
  logic [LOAD_W-1:0] preload_q;
  logic [LOAD_W-1:0] base;
  logic              force_az;
  logic              tmr_ld, tmr_clr, tmr_inc, tmr_full;
  logic [TMR_W-1:0]  tmr_val;
  logic              pol_en, pol_q, cap, cap_ovr;
  phase_e            ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n)      preload_q <= '0;
    else if (!ld_n) preload_q <= load_val;
  end

  assign force_az = !run_en || !ld_n;
  assign base     = ld_n ? preload_q : load_val;

  dsq_timer #(.TMR_W(TMR_W), .LOAD_W(LOAD_W)) u_timer (
    .clk    (clk),
    .rst_n  (rs_n),
    .clr_i  (tmr_clr),
    .ld_i   (tmr_ld),
    .inc_i  (tmr_inc),
    .base_i (base),
    .val_o  (tmr_val),
    .full_o (tmr_full)
  );

  dsq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rs_n),
    .force_i   (force_az),
    .cmp_i     (cmp_i),
    .pol_i     (pol_q),
    .full_i    (tmr_full),
    .phase_o   (ph),
    .tmr_ld_o  (tmr_ld),
    .tmr_clr_o (tmr_clr),
    .tmr_inc_o (tmr_inc),
    .pol_en_o  (pol_en),
    .cap_o     (cap),
    .cap_ovr_o (cap_ovr)
  );

  dsq_capture #(.TMR_W(TMR_W)) u_cap (
    .clk       (clk),
    .rst_n     (rs_n),
    .cmp_i     (cmp_i),
    .pol_en_i  (pol_en),
    .cap_i     (cap),
    .cap_ovr_i (cap_ovr),
    .tmr_i     (tmr_val),
    .pol_o     (pol_q),
    .valid_o   (res_valid),
    .count_o   (res_count),
    .res_pol_o (res_pol),
    .ovr_o     (res_ovr)
  );

  assign phase = ph;

  assert_deint_from_zero_R4: assert property (@(posedge clk) disable iff (!rs_n)
    (ph == PH_DEINT && $past(ph) == PH_INT) |-> tmr_val == '0);

  assert_restart_base_R8: assert property (@(posedge clk) disable iff (!rs_n)
    $past(force_az) |-> tmr_val == {$past(base), {(TMR_W-LOAD_W){1'b0}}});
endmodule

// File: tb/tb_dslope_sequencer.sv
module tb_dslope_sequencer;
  logic        clk = 1'b0;
  logic        rst_n, cmp_i, run_en, ld_n;
  logic [7:0]  load_val;
  logic [1:0]  phase;
  logic        res_valid, res_pol, res_ovr;
  logic [15:0] res_count;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // behavioural reference state
  int m_ph = 0, m_e = 0, m_L = 0, m_pol = 0;
  int m_rc = 0, m_ro = 0, m_rp = 0, m_val = 0;
  bit m_rs1 = 0, m_rs2 = 0;

  always #4 clk = ~clk;

  dslope_sequencer dut (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i), .run_en(run_en), .ld_n(ld_n),
    .load_val(load_val), .phase(phase), .res_valid(res_valid),
    .res_count(res_count), .res_pol(res_pol), .res_ovr(res_ovr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic capture(input int v, input int o);
    m_rc = v; m_ro = o; m_rp = m_pol; m_val = 1; m_ph = 0;
  endtask

  always @(posedge clk) begin
    int len;
    if (!rst_n) begin
      m_ph = 0; m_e = 0; m_L = 0; m_pol = 0;
      m_rc = 0; m_ro = 0; m_rp = 0; m_val = 0;
      m_rs1 = 0; m_rs2 = 0;
    end else begin
      if (m_rs2) begin
        len = 65536 - 256 * m_L;
        m_val = 0;
        if (!run_en || !ld_n) begin
          m_ph = 1; m_e = 0;
        end else begin
          case (m_ph)
            0: if (cmp_i) begin m_ph = 1; m_e = 0; end
            1: if (m_e == len - 1) begin m_ph = 2; m_e = 0; end else m_e++;
            2: if (m_e == len - 1) begin m_ph = 3; m_e = 0; m_pol = cmp_i; end else m_e++;
            default: begin
              if (cmp_i != m_pol[0]) capture(m_e, 0);
              else if (m_e == 65535) capture(65535, 1);
              else m_e++;
            end
          endcase
        end
        if (!ld_n) m_L = load_val;
      end
      m_rs2 = m_rs1;
      m_rs1 = 1;
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    string tag;
    if (m_rs2 && !done) begin
      case (m_ph)
        0: tag = "R6";
        1: tag = "R2";
        2: tag = "R3";
        default: tag = "R4";
      endcase
      chk(phase == m_ph[1:0], tag, phase, m_ph);
      chk(res_valid == m_val[0] && res_count == m_rc[15:0] &&
          res_pol == m_rp[0] && res_ovr == m_ro[0], "R9",
          {res_valid, res_pol, res_ovr, res_count},
          {m_val[0], m_rp[0], m_ro[0], m_rc[15:0]});
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc >= 190000 && !done) begin
      done = 1;
      chk(0, "watchdog", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wait_phase(input logic [1:0] p);
    while (phase !== p) @(negedge clk);
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (res_valid !== 1'b1);
  endtask

  initial begin
    int n;
    rst_n = 0; run_en = 1; ld_n = 1; cmp_i = 0; load_val = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(phase == 2'b00, "R7", phase, 0);
    chk(res_valid == 0 && res_count == 0 && res_pol == 0 && res_ovr == 0, "R7",
        res_count, 0);
    repeat (5) @(negedge clk);
    chk(phase == 2'b00, "R6", phase, 0);

    // R8 load forces auto-zero
    ld_n = 0; load_val = 8'hFF;
    @(negedge clk);
    ld_n = 1; cmp_i = 1;
    @(negedge clk);
    chk(phase == 2'b01, "R8", phase, 1);

    // R4 conversion with comparator falling after 37 cycles
    wait_phase(2'b11);
    repeat (37) @(negedge clk);
    cmp_i = 0;
    wait_valid();
    chk(res_count == 37, "R4", res_count, 37);
    chk(res_pol == 1, "R9", res_pol, 1);
    chk(res_ovr == 0, "R5", res_ovr, 0);
    chk(phase == 2'b00, "R6", phase, 0);
    repeat (10) @(negedge clk);
    chk(phase == 2'b00, "R6", phase, 0);
    cmp_i = 1;
    @(negedge clk);
    chk(phase == 2'b01, "R6", phase, 1);

    // R2 / R3 phase lengths for preload 0xFF, negative polarity
    n = 1;
    @(negedge clk);
    while (phase == 2'b01) begin n++; @(negedge clk); end
    chk(n == 256, "R2", n, 256);
    cmp_i = 0;
    n = 0;
    while (phase == 2'b10) begin n++; @(negedge clk); end
    chk(n == 256, "R3", n, 256);
    repeat (100) @(negedge clk);
    cmp_i = 1;
    wait_valid();
    chk(res_count == 100, "R4", res_count, 100);
    chk(res_pol == 0, "R9", res_pol, 0);
    @(negedge clk);
    chk(res_valid == 0, "R9", res_valid, 0);

    // R8 new preload, then drop run enable inside integrate
    wait_phase(2'b01);
    ld_n = 0; load_val = 8'hFE;
    @(negedge clk);
    ld_n = 1;
    wait_phase(2'b10);
    repeat (20) @(negedge clk);
    run_en = 0;
    @(negedge clk);
    run_en = 1;
    chk(phase == 2'b01, "R8", phase, 1);
    n = 1;
    @(negedge clk);
    while (phase == 2'b01) begin n++; @(negedge clk); end
    chk(n == 512, "R2", n, 512);

    // R5 overrange: comparator never changes
    wait_phase(2'b11);
    wait_valid();
    chk(res_ovr == 1, "R5", res_ovr, 1);
    chk(res_count == 16'hFFFF, "R5", res_count, 65535);

    // R10 comparator change on the full-scale cycle
    wait_phase(2'b11);
    repeat (65535) @(negedge clk);
    cmp_i = 0;
    wait_valid();
    chk(res_ovr == 0, "R10", res_ovr, 0);
    chk(res_count == 16'hFFFF, "R10", res_count, 65535);
    chk(res_pol == 1, "R10", res_pol, 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule